// File: doc/BRIEF.md
# Read Strobe Gate Controller

This block sits in the read path of a memory-facing PHY. It decides, cycle by cycle, whether the incoming read strobe lanes may reach the capture FIFO. The gate stays shut until the controller issues its read-data-enable. It then opens after a programmable number of PHY clock cycles. It stays open until the controller reports both the pre/post-amble indication and the read-enable-bar indication high. An optional second programmable delay can hold it open beyond that point.

A four-state machine (idle, wait-open, open, wait-close) drives the gate. Two small down-counters time the two delays, and a per-lane AND stage masks the strobes. If a new read-enable arrives while the close delay is still running, the gate does not drop. Instead the machine returns to open, so back-to-back reads see an uninterrupted gate.

Top module: `rd_strobe_gate`

## Requirements
- R1: After any clock edge at which rst_ni is low, gate_o is 0, every strobe_gated_o lane is 0, and the controller is idle. From idle the gate stays closed for as long as rd_en_i is low.
- R2: Each bit of strobe_gated_o equals the same bit of strobe_i while gate_o is 1 and is 0 while gate_o is 0.
- R3: With open_dly_i = N (0 to 15), a rising clock edge that samples rd_en_i high in idle counts as edge 1. gate_o becomes 1 right after edge N+1, so N = 0 opens in the cycle after the trigger.
- R4: A read-enable sampled while the open delay is still counting neither restarts nor shortens that delay.
- R5: While open, gate_o stays 1 unless amble_i and re_bar_i are sampled high at the same edge. Either one alone has no effect.
- R6: With close_dly_i = M (0 to 15), the edge that samples amble_i and re_bar_i both high counts as edge 1. gate_o becomes 0 right after edge M+1.
- R7: A read-enable sampled during the close delay returns the controller to open, with gate_o staying 1. This includes the edge at which the close delay would expire. The gate then closes only on a fresh close condition.
- R8: The close condition is ignored in idle and during the open delay. A read-enable sampled while open has no effect.
- R9: If the read-enable and the close condition are sampled at the same edge while open, the close takes effect and the read-enable is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PHY clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| rd_en_i | input | 1 | Read-data-enable from the controller |
| amble_i | input | 1 | Read pre/post-amble indication |
| re_bar_i | input | 1 | Read-enable-bar indication |
| open_dly_i | input | DLY_W (4) | Open delay in PHY clock cycles |
| close_dly_i | input | DLY_W (4) | Extra close delay in PHY clock cycles |
| strobe_i | input | LANES (2) | Incoming read strobe lanes |
| gate_o | output | 1 | Gate state, 1 = strobes pass |
| strobe_gated_o | output | LANES (2) | Strobe lanes masked by the gate |

## Verification
Two functions can collide in one cycle. The first pair is the expiry of the close-delay count and a new read-enable. The bench starts a close with a delay of three and then places the read-enable one, two and three cycles later, and once more one cycle after expiry. The gate must stay high in the first three cases and show exactly one low cycle in the last. The second pair is the read-enable and the close condition sampled together while open. Here the gate is judged to drop after that single edge. A full sweep of every open and close delay pairing backs up the arithmetic edge counts.

// File: rtl/rsg_pkg.sv
`timescale 1ns/1ps
// Shared types for the read strobe gate controller.
// Assumes: the state encoding is only consumed inside this block and its checker.
package rsg_pkg;

    // Gate controller states.
    typedef enum logic [1:0] {
        GS_IDLE       = 2'd0,
        GS_WAIT_OPEN  = 2'd1,
        GS_OPEN       = 2'd2,
        GS_WAIT_CLOSE = 2'd3
    } gate_state_e;

endpackage

// File: rtl/rsg_dly_cnt.sv
`timescale 1ns/1ps
// Loadable down-counter used to time one programmable delay.
// Loading a value N then decrementing once per cycle gives last_o after
// N-1 decrements, so a waiting state that leaves on last_o lasts N cycles.
// Assumes: the owner never decrements a counter loaded with zero
// (a zero delay bypasses the waiting state entirely).
module rsg_dly_cnt #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         last_o
);

    logic [W-1:0] cnt_q;

    // Count register: load has priority, decrement saturates at zero.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    // Final cycle of the delay window.
    assign last_o = (cnt_q == W'(1));

endmodule

// File: rtl/rsg_fsm.sv
`timescale 1ns/1ps
// Gate sequencing state machine.
// Idle -> (read-enable) -> wait-open -> open -> (close condition) ->
// wait-close -> idle. A zero delay skips the matching waiting state.
// A read-enable during wait-close returns to open; during wait-open
// and open it is ignored. The close condition is only acted on in open.
// Assumes: the close condition is already the AND of both indications.
module rsg_fsm
    import rsg_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rd_en_i,
    input  logic             close_req_i,
    input  logic [DLY_W-1:0] open_dly_i,
    input  logic [DLY_W-1:0] close_dly_i,
    input  logic             open_last_i,
    input  logic             close_last_i,
    output logic             open_load_o,
    output logic             open_dec_o,
    output logic             close_load_o,
    output logic             close_dec_o,
    output logic             gate_o,
    output gate_state_e      state_o
);

    gate_state_e state_q;
    gate_state_e state_d;

    logic open_zero;
    logic close_zero;

    assign open_zero  = (open_dly_i == '0);
    assign close_zero = (close_dly_i == '0);

    // Next-state and counter control decode.
    always_comb begin
        state_d      = state_q;
        open_load_o  = 1'b0;
        open_dec_o   = 1'b0;
        close_load_o = 1'b0;
        close_dec_o  = 1'b0;
        unique case (state_q)
            GS_IDLE: begin
                if (rd_en_i) begin
                    if (open_zero) begin
                        state_d = GS_OPEN;
                    end else begin
                        state_d     = GS_WAIT_OPEN;
                        open_load_o = 1'b1;
                    end
                end
            end
            GS_WAIT_OPEN: begin
                open_dec_o = 1'b1;
                if (open_last_i) begin
                    state_d = GS_OPEN;
                end
            end
            GS_OPEN: begin
                if (close_req_i) begin
                    if (close_zero) begin
                        state_d = GS_IDLE;
                    end else begin
                        state_d      = GS_WAIT_CLOSE;
                        close_load_o = 1'b1;
                    end
                end
            end
            GS_WAIT_CLOSE: begin
                if (rd_en_i) begin
                    state_d = GS_OPEN;
                end else begin
                    close_dec_o = 1'b1;
                    if (close_last_i) begin
                        state_d = GS_IDLE;
                    end
                end
            end
            default: state_d = GS_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= GS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Gate is open in open and while the close delay runs.
    assign gate_o  = (state_q == GS_OPEN) || (state_q == GS_WAIT_CLOSE);
    assign state_o = state_q;

endmodule

// File: rtl/rsg_strobe_mask.sv
`timescale 1ns/1ps
// Per-lane strobe mask: each lane passes only while the gate is high.
// Assumes: gate_i comes straight from a register so the mask adds one AND level.
module rsg_strobe_mask #(
    parameter int LANES = 2
) (
    input  logic             gate_i,
    input  logic [LANES-1:0] strobe_i,
    output logic [LANES-1:0] strobe_o
);

    // One AND gate per strobe lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign strobe_o[g] = strobe_i[g] & gate_i;
    end

endmodule

// File: rtl/rd_strobe_gate.sv
`timescale 1ns/1ps
// Read strobe gate controller (top).
// Opens the strobe gate a programmable number of PHY cycles after the
// read-data-enable, and closes it once the amble and read-enable-bar
// indications are both high, optionally after a second programmable delay.
// Assumes: all inputs are synchronous to clk_i.
module rd_strobe_gate
    import rsg_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DLY_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rd_en_i,
    input  logic             amble_i,
    input  logic             re_bar_i,
    input  logic [DLY_W-1:0] open_dly_i,
    input  logic [DLY_W-1:0] close_dly_i,
    input  logic [LANES-1:0] strobe_i,
    output logic             gate_o,
    output logic [LANES-1:0] strobe_gated_o
);

    logic        close_req;
    logic        open_load;
    logic        open_dec;
    logic        open_last;
    logic        close_load;
    logic        close_dec;
    logic        close_last;
    logic        gate;
    gate_state_e fsm_state;

    // Close condition needs both controller indications at once.
    assign close_req = amble_i & re_bar_i;

    rsg_fsm #(
        .DLY_W (DLY_W)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .rd_en_i      (rd_en_i),
        .close_req_i  (close_req),
        .open_dly_i   (open_dly_i),
        .close_dly_i  (close_dly_i),
        .open_last_i  (open_last),
        .close_last_i (close_last),
        .open_load_o  (open_load),
        .open_dec_o   (open_dec),
        .close_load_o (close_load),
        .close_dec_o  (close_dec),
        .gate_o       (gate),
        .state_o      (fsm_state)
    );

    rsg_dly_cnt #(
        .W (DLY_W)
    ) u_open_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (open_load),
        .load_val_i (open_dly_i),
        .dec_i      (open_dec),
        .last_o     (open_last)
    );

    rsg_dly_cnt #(
        .W (DLY_W)
    ) u_close_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (close_load),
        .load_val_i (close_dly_i),
        .dec_i      (close_dec),
        .last_o     (close_last)
    );

    rsg_strobe_mask #(
        .LANES (LANES)
    ) u_mask (
        .gate_i   (gate),
        .strobe_i (strobe_i),
        .strobe_o (strobe_gated_o)
    );

    assign gate_o = gate;

endmodule

// File: rtl/rd_strobe_gate_chk.sv
`timescale 1ns/1ps
// Assertion checker for the read strobe gate controller, bound to the top.
// Assumes: state_i is the controller's state register.
module rd_strobe_gate_chk
    import rsg_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DLY_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rd_en_i,
    input  logic             amble_i,
    input  logic             re_bar_i,
    input  logic [DLY_W-1:0] open_dly_i,
    input  logic [DLY_W-1:0] close_dly_i,
    input  logic [LANES-1:0] strobe_i,
    input  logic             gate_o,
    input  logic [LANES-1:0] strobe_gated_o,
    input  gate_state_e      state_i
);

    a_r1_closed_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> (!gate_o && (strobe_gated_o == '0)));

    a_r1_idle_stays_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == GS_IDLE && !rd_en_i) |=> !gate_o);

    a_r2_no_leak: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gate_o |-> (strobe_gated_o == '0));

    a_r2_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_o |-> (strobe_gated_o == strobe_i));

    a_r3_zero_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == GS_IDLE && rd_en_i && open_dly_i == '0) |=> gate_o);

    a_r3_rise_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_o) |-> ($past(state_i) == GS_IDLE || $past(state_i) == GS_WAIT_OPEN));

    a_r5_hold_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == GS_OPEN && !(amble_i && re_bar_i)) |=> gate_o);

    a_r6_zero_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == GS_OPEN && amble_i && re_bar_i && close_dly_i == '0) |=> !gate_o);

    a_r7_reopen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == GS_WAIT_CLOSE && rd_en_i) |=> (state_i == GS_OPEN && gate_o));

    a_r8_idle_ignores_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == GS_IDLE && !rd_en_i && amble_i && re_bar_i) |=> (state_i == GS_IDLE));

endmodule

bind rd_strobe_gate rd_strobe_gate_chk #(
    .LANES (LANES),
    .DLY_W (DLY_W)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rd_en_i        (rd_en_i),
    .amble_i        (amble_i),
    .re_bar_i       (re_bar_i),
    .open_dly_i     (open_dly_i),
    .close_dly_i    (close_dly_i),
    .strobe_i       (strobe_i),
    .gate_o         (gate_o),
    .strobe_gated_o (strobe_gated_o),
    .state_i        (fsm_state)
);

// File: tb/rd_strobe_gate_tb.sv
`timescale 1ns/1ps
// Self-checking bench: full sweep of open/close delays plus directed corners.
module rd_strobe_gate_tb;

    localparam int LANES = 2;
    localparam int DLY_W = 4;
    localparam int DMAX  = (1 << DLY_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rd_en;
    logic             amble;
    logic             re_bar;
    logic [DLY_W-1:0] open_dly;
    logic [DLY_W-1:0] close_dly;
    logic [LANES-1:0] strobe;
    logic             gate;
    logic [LANES-1:0] gated;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rd_strobe_gate #(
        .LANES (LANES),
        .DLY_W (DLY_W)
    ) u_dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .rd_en_i        (rd_en),
        .amble_i        (amble),
        .re_bar_i       (re_bar),
        .open_dly_i     (open_dly),
        .close_dly_i    (close_dly),
        .strobe_i       (strobe),
        .gate_o         (gate),
        .strobe_gated_o (gated)
    );

    // Advance one edge, step the strobe pattern, settle away from the edge.
    task automatic tick();
        @(posedge clk);
        #2;
        strobe = strobe + LANES'(1);
        #1;
    endtask

    // Compare gate and masked strobes against the expected gate value.
    task automatic chk(input string req, input logic exp_gate);
        logic [LANES-1:0] exp_s;
        exp_s = exp_gate ? strobe : '0;
        checks++;
        if (gate !== exp_gate || gated !== exp_s) begin
            fails++;
            $display("FAIL %s: gate=%0b exp=%0b gated=%b exp=%b at %0t",
                     req, gate, exp_gate, gated, exp_s, $time);
        end
    endtask

    // Pulse both close indications for one edge.
    task automatic close_pulse();
        amble  = 1'b1;
        re_bar = 1'b1;
        tick();
        amble  = 1'b0;
        re_bar = 1'b0;
    endtask

    initial begin
        rst_n     = 1'b0;
        rd_en     = 1'b0;
        amble     = 1'b0;
        re_bar    = 1'b0;
        open_dly  = '0;
        close_dly = '0;
        strobe    = '1;

        // R1: reset holds the gate closed even with a read-enable present.
        rd_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R1 reset", 1'b0);
        end
        rd_en = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R1 idle", 1'b0);
        end

        // R8: close condition in idle is ignored.
        amble  = 1'b1;
        re_bar = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R8 idle close ignored", 1'b0);
        end
        amble  = 1'b0;
        re_bar = 1'b0;

        // Sweep every open/close delay pair (R2, R3, R4, R5, R6).
        for (int n = 0; n <= DMAX; n++) begin
            for (int m = 0; m <= DMAX; m++) begin
                open_dly  = DLY_W'(n);
                close_dly = DLY_W'(m);
                rd_en = 1'b1;
                tick();
                rd_en = 1'b0;
                chk("R3 open edge0", n == 0);
                for (int e = 1; e <= n + 1; e++) begin
                    if (e == 1 && n >= 2) rd_en = 1'b1;  // R4 retrigger ignored
                    tick();
                    rd_en = 1'b0;
                    chk((n >= 2) ? "R4 open timing" : "R3 open timing", e >= n);
                end
                amble = 1'b1;
                tick();
                chk("R5 amble alone", 1'b1);
                amble  = 1'b0;
                re_bar = 1'b1;
                tick();
                chk("R5 re_bar alone", 1'b1);
                re_bar = 1'b0;
                tick();
                chk("R2 open pass", 1'b1);
                close_pulse();
                chk("R6 close edge0", m > 0);
                for (int e = 1; e <= m + 1; e++) begin
                    tick();
                    chk("R6 close timing", e < m);
                end
            end
        end

        // R8: close condition during the open delay is ignored.
        open_dly  = DLY_W'(5);
        close_dly = '0;
        rd_en = 1'b1;
        tick();
        rd_en  = 1'b0;
        amble  = 1'b1;
        re_bar = 1'b1;
        for (int e = 1; e <= 4; e++) begin
            tick();
            chk("R8 wait-open ignores close", 1'b0);
        end
        amble  = 1'b0;
        re_bar = 1'b0;
        tick();
        chk("R8 opens on time", 1'b1);

        // R8: read-enable while open has no effect; R9: same-edge collision closes.
        rd_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R8 rd_en while open", 1'b1);
        end
        amble  = 1'b1;
        re_bar = 1'b1;
        tick();
        chk("R9 close beats rd_en", 1'b0);
        rd_en  = 1'b0;
        amble  = 1'b0;
        re_bar = 1'b0;
        tick();
        chk("R9 stays closed", 1'b0);

        // R7: read-enable during the close delay, including the expiry edge.
        open_dly  = '0;
        close_dly = DLY_W'(3);
        for (int d = 1; d <= 4; d++) begin
            rd_en = 1'b1;
            tick();
            rd_en = 1'b0;
            chk("R7 setup open", 1'b1);
            close_pulse();
            chk("R7 close started", 1'b1);
            for (int t = 1; t < d; t++) begin
                tick();
                chk("R7 close countdown", t < 3);
            end
            rd_en = 1'b1;
            tick();
            rd_en = 1'b0;
            chk("R7 reopen", 1'b1);
            for (int i = 0; i < 4; i++) begin
                tick();
                chk("R7 held open", 1'b1);
            end
            close_dly = '0;
            close_pulse();
            chk("R7 fresh close", 1'b0);
            close_dly = DLY_W'(3);
            tick();
            chk("R7 idle", 1'b0);
        end

        // R1: reset while open forces the gate closed.
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        chk("R1 pre-reset open", 1'b1);
        rst_n = 1'b0;
        tick();
        chk("R1 mid-run reset", 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1 after reset", 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule